// File: doc/BRIEF.md
# Card Data FIFO Engine

This block is the data half of a memory-card host controller. A small word FIFO sits between a host register port and a byte-wide card data path. When data flows from the card to the host, each accepted card byte is placed into a word little-endian, and the word enters the FIFO once it holds four bytes. A transfer whose length is not a multiple of four ends by pushing the partial word. When data flows from the host to the card, words leave the FIFO and are sent to the card one byte per cycle, lowest byte first.

Software programs a byte length and then writes a control byte. Bit 0 of that byte starts a transfer and bit 1 selects the direction. Two counters track the transfer: the remaining card bytes, and the remaining host words, which starts at the length rounded up to whole words. The host moves words through a data window. The block reports FIFO level flags for the active direction and two sticky end-of-transfer bits. It drops the enable bit on its own once both counters reach zero.

Top module: `card_fifo_engine`

## Requirements
- R1: After reset, all outputs are zero: control, both counters, status, read data, `rx_ready` and `tx_valid`.
- R2: A control write with bit 0 set does four things. It loads the byte counter from the length register and the word counter with (length+3)>>2. It empties the FIFO and clears the end bits. Any control write discards a partly packed or partly sent word, and no data moves in the cycle of a control write. Each byte moved to or from the card decrements the byte counter by one.
- R3: The FIFO holds 16 words of 32 bits. Whether a push or a pop is accepted depends on the occupancy at the start of the cycle. A push into a full FIFO is dropped, even if a pop happens in the same cycle. A push and a pop in the same cycle are both applied otherwise.
- R4: In read direction (control bit 1 = 1), the first card byte of a word lands in bits 7:0 and each following byte lands 8 bits higher. The word is pushed after its fourth byte, or after the last byte of the transfer, with the unused upper bytes zero. The words come out of the host window in arrival order.
- R5: `rx_ready` is high only when enabled, in read direction, with a nonzero byte counter and fewer than 16 words stored. At most one byte is accepted per cycle.
- R6: In write direction (control bit 1 = 0), `tx_valid` is high only when enabled, with a nonzero byte counter and a byte on hand. Each word is sent as byte 0 first through byte 3 last.
- R7: A host window read or write decrements the word counter when that counter is nonzero, and does nothing when it is zero. A write pushes only in write direction. A read pops and returns the oldest word only in read direction with a nonempty FIFO. Every other read returns 0.
- R8: While enabled with a zero byte counter, status bits 8 and 10 are set. They stay set until the next control write with bit 0 set.
- R9: Control bit 0 clears one cycle after both counters are zero while it is set.
- R10: While enabled with either counter nonzero, the block shows level flags for the current direction only; at other times all of them are zero. The write-direction flags are: active (bit 12), at most 8 words (bit 14), 16 words (bit 16), empty (bit 18) and nonempty (bit 20). The read-direction flags are: active (bit 13), at least 8 words (bit 15), 16 words (bit 17), empty (bit 19) and nonempty (bit 21).
- R11: With control bit 0 clear, no card byte is accepted or offered, and the byte counter holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| len_we | input | 1 | Length register write strobe |
| len_wdata | input | 16 | Transfer length in bytes |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control value: bit 0 enable, bit 1 read direction |
| win_we | input | 1 | Host data window write |
| win_wdata | input | 32 | Host word to push |
| win_re | input | 1 | Host data window read |
| win_rdata | output | 32 | Word returned by a window read |
| rx_valid | input | 1 | Card offers a byte |
| rx_byte | input | 8 | Byte from the card |
| rx_ready | output | 1 | Engine accepts the card byte |
| tx_valid | output | 1 | Engine offers a byte to the card |
| tx_byte | output | 8 | Byte to the card |
| tx_ready | input | 1 | Card takes the byte |
| ctrl | output | 8 | Control register contents |
| byte_cnt | output | 16 | Remaining card bytes |
| word_cnt | output | 16 | Remaining host words |
| status | output | 22 | End bits and level flags |

## Verification
The engine-side FIFO operation and the host window can strike the FIFO in the same cycle. In read direction, a packer push can coincide with a host pop. In write direction, a host push can coincide with an unpacker pop, including the case where the FIFO is already full. The bench provokes this by filling the FIFO to 16 words with the other side stalled, then releasing that side while the host keeps accessing the window. A queue model applies both operations against the occupancy at the start of the cycle and judges every output on every clock.

// File: rtl/cfe_pkg.sv
package cfe_pkg;
  localparam int ST_W        = 22;
  localparam int CTL_EN      = 0;
  localparam int CTL_RD      = 1;
  localparam int ST_DEND     = 8;
  localparam int ST_BEND     = 10;
  localparam int ST_TX_ACT   = 12;
  localparam int ST_RX_ACT   = 13;
  localparam int ST_TX_HALF  = 14;
  localparam int ST_RX_HALF  = 15;
  localparam int ST_TX_FULL  = 16;
  localparam int ST_RX_FULL  = 17;
  localparam int ST_TX_EMPTY = 18;
  localparam int ST_RX_EMPTY = 19;
  localparam int ST_TX_AVAIL = 20;
  localparam int ST_RX_AVAIL = 21;
  localparam logic [ST_W-1:0] ST_TX_MASK = 22'h155000;
  localparam logic [ST_W-1:0] ST_RX_MASK = 22'h2AA000;

  // host word count for a byte length, rounded up to whole words
  function automatic logic [31:0] words_of(input logic [31:0] nbytes, input int lanes);
    return (nbytes + 32'(lanes - 1)) / 32'(lanes);
  endfunction

  // place one byte into lane idx of a word
  function automatic logic [31:0] lane_put(input logic [31:0] acc, input logic [7:0] b,
                                           input logic [1:0] idx);
    return acc | (32'(b) << {idx, 3'b000});
  endfunction
endpackage

// File: rtl/cfe_fifo.sv
module cfe_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 32,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [W-1:0]     wdata,
  input  logic             pop,
  output logic [W-1:0]     head,
  output logic [CNT_W-1:0] count,
  output logic             push_ok,
  output logic             pop_ok
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign push_ok = push && (count < CNT_W'(DEPTH)) && !flush;
  assign pop_ok  = pop && (count != '0) && !flush;
  assign head    = mem[rp];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else if (flush) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (push_ok) wp <= bump(wp);
      if (pop_ok)  rp <= bump(rp);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/cfe_packer.sv
module cfe_packer import cfe_pkg::*; #(
  parameter int W = 32,
  localparam int LANES = W / 8,
  localparam int IW    = $clog2(LANES)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         take,
  input  logic [7:0]   byte_in,
  input  logic         last,
  output logic         push,
  output logic [W-1:0] word
);
  logic [W-1:0]  acc;
  logic [IW-1:0] idx;

  assign word = lane_put(acc, byte_in, idx);
  assign push = take && ((idx == IW'(LANES - 1)) || last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0; idx <= '0;
    end else if (clr || push) begin
      acc <= '0; idx <= '0;
    end else if (take) begin
      acc <= word; idx <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/cfe_unpacker.sv
module cfe_unpacker #(
  parameter int W = 32,
  localparam int LANES = W / 8,
  localparam int IW    = $clog2(LANES)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] head,
  input  logic         send,
  output logic [7:0]   byte_out,
  output logic         need_pop,
  output logic         have
);
  logic [W-1:0]  sh;
  logic [IW-1:0] left;

  assign need_pop = (left == '0);
  assign have     = !need_pop;
  assign byte_out = need_pop ? head[7:0] : sh[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0; left <= '0;
    end else if (clr) begin
      sh <= '0; left <= '0;
    end else if (send) begin
      if (need_pop) begin
        sh <= head >> 8; left <= IW'(LANES - 1);
      end else begin
        sh <= sh >> 8; left <= left - 1'b1;
      end
    end
  end
endmodule

// File: rtl/card_fifo_engine.sv
module card_fifo_engine import cfe_pkg::*; #(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 32,
  parameter int LEN_W  = 16,
  parameter int CTL_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              len_we,
  input  logic [LEN_W-1:0]  len_wdata,
  input  logic              ctl_we,
  input  logic [CTL_W-1:0]  ctl_wdata,
  input  logic              win_we,
  input  logic [WORD_W-1:0] win_wdata,
  input  logic              win_re,
  output logic [WORD_W-1:0] win_rdata,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_byte,
  input  logic              tx_ready,
  output logic [CTL_W-1:0]  ctrl,
  output logic [LEN_W-1:0]  byte_cnt,
  output logic [LEN_W-1:0]  word_cnt,
  output logic [ST_W-1:0]   status
);
  localparam int LANES = WORD_W / 8;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int HALF  = DEPTH / 2;

  logic [LEN_W-1:0]  len_q;
  logic              dend_q;
  logic              en, dir_rd, load, active;
  logic              rx_take, tx_send, host_acc, host_push, host_pop;
  logic              pk_push, unp_need, unp_have;
  logic              fifo_push, fifo_pop, fifo_push_ok, fifo_pop_ok;
  logic [WORD_W-1:0] pk_word, fifo_wdata, fifo_head;
  logic [CNT_W-1:0]  fifo_cnt;
  logic              fifo_empty, fifo_full;

  assign en         = ctrl[CTL_EN];
  assign dir_rd     = ctrl[CTL_RD];
  assign load       = ctl_we && ctl_wdata[CTL_EN];
  assign fifo_empty = (fifo_cnt == '0);
  assign fifo_full  = (fifo_cnt == CNT_W'(DEPTH));
  assign active     = en && ((byte_cnt != '0) || (word_cnt != '0));

  assign rx_ready = en && dir_rd && (byte_cnt != '0) && !fifo_full && !ctl_we;
  assign rx_take  = rx_valid && rx_ready;
  assign tx_valid = en && !dir_rd && (byte_cnt != '0) && (unp_have || !fifo_empty) && !ctl_we;
  assign tx_send  = tx_valid && tx_ready;

  assign host_acc  = (win_we || win_re) && (word_cnt != '0) && !ctl_we;
  assign host_push = host_acc && win_we && !dir_rd;
  assign host_pop  = host_acc && win_re && dir_rd;
  assign win_rdata = (host_pop && !fifo_empty) ? fifo_head : '0;

  assign fifo_push  = dir_rd ? pk_push : host_push;
  assign fifo_wdata = dir_rd ? pk_word : win_wdata;
  assign fifo_pop   = dir_rd ? host_pop : (tx_send && unp_need);

  cfe_fifo #(.DEPTH(DEPTH), .W(WORD_W)) fifo_i (
    .clk(clk), .rst_n(rst_n), .flush(load), .push(fifo_push), .wdata(fifo_wdata),
    .pop(fifo_pop), .head(fifo_head), .count(fifo_cnt),
    .push_ok(fifo_push_ok), .pop_ok(fifo_pop_ok)
  );

  cfe_packer #(.W(WORD_W)) pack_i (
    .clk(clk), .rst_n(rst_n), .clr(ctl_we), .take(rx_take), .byte_in(rx_byte),
    .last(byte_cnt == LEN_W'(1)), .push(pk_push), .word(pk_word)
  );

  cfe_unpacker #(.W(WORD_W)) unpack_i (
    .clk(clk), .rst_n(rst_n), .clr(ctl_we), .head(fifo_head), .send(tx_send),
    .byte_out(tx_byte), .need_pop(unp_need), .have(unp_have)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
    end else if (len_we) begin
      len_q <= len_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0; byte_cnt <= '0; word_cnt <= '0; dend_q <= 1'b0;
    end else if (ctl_we) begin
      ctrl <= ctl_wdata;
      if (ctl_wdata[CTL_EN]) begin
        byte_cnt <= len_q;
        word_cnt <= LEN_W'(words_of(32'(len_q), LANES));
        dend_q   <= 1'b0;
      end
    end else begin
      if (rx_take || tx_send) byte_cnt <= byte_cnt - 1'b1;
      if (host_acc) word_cnt <= word_cnt - 1'b1;
      if (en && byte_cnt == '0) dend_q <= 1'b1;
      if (en && byte_cnt == '0 && word_cnt == '0) ctrl[CTL_EN] <= 1'b0;
    end
  end

  always_comb begin
    status = '0;
    status[ST_DEND] = dend_q;
    status[ST_BEND] = dend_q;
    if (active) begin
      if (dir_rd) begin
        status[ST_RX_ACT]   = 1'b1;
        status[ST_RX_HALF]  = (fifo_cnt >= CNT_W'(HALF));
        status[ST_RX_FULL]  = fifo_full;
        status[ST_RX_EMPTY] = fifo_empty;
        status[ST_RX_AVAIL] = !fifo_empty;
      end else begin
        status[ST_TX_ACT]   = 1'b1;
        status[ST_TX_HALF]  = (fifo_cnt <= CNT_W'(HALF));
        status[ST_TX_FULL]  = fifo_full;
        status[ST_TX_EMPTY] = fifo_empty;
        status[ST_TX_AVAIL] = !fifo_empty;
      end
    end
  end
endmodule

// File: rtl/cfe_checker.sv
module cfe_checker import cfe_pkg::*; #(
  parameter int DEPTH = 16,
  parameter int LEN_W = 16,
  parameter int CTL_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_we,
  input logic [CTL_W-1:0] ctrl,
  input logic [LEN_W-1:0] byte_cnt,
  input logic [LEN_W-1:0] word_cnt,
  input logic [ST_W-1:0]  status,
  input logic             rx_ready,
  input logic             rx_take,
  input logic             tx_valid,
  input logic             tx_send,
  input logic             win_re,
  input logic [31:0]      win_rdata,
  input logic [CNT_W-1:0] fifo_cnt
);
  // R3
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CNT_W'(DEPTH));

  // R5
  rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> (ctrl[CTL_EN] && ctrl[CTL_RD] && fifo_cnt < CNT_W'(DEPTH) && byte_cnt != '0));

  // R6
  tx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (ctrl[CTL_EN] && !ctrl[CTL_RD] && byte_cnt != '0));

  // R2
  byte_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_take || tx_send) |=> (byte_cnt == $past(byte_cnt) - 1'b1));

  // R7
  idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_re && word_cnt == '0) |-> (win_rdata == '0));

  // R8
  end_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[CTL_EN] && byte_cnt == '0 && !ctl_we) |=> (status[ST_DEND] && status[ST_BEND]));

  // R9
  enable_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[CTL_EN] && byte_cnt == '0 && word_cnt == '0 && !ctl_we) |=> !ctrl[CTL_EN]);

  // R10
  one_side_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(((status & ST_TX_MASK) != '0) && ((status & ST_RX_MASK) != '0)));

  // R11
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[CTL_EN] |-> (!rx_ready && !tx_valid));
endmodule

bind card_fifo_engine cfe_checker #(.DEPTH(DEPTH), .LEN_W(LEN_W), .CTL_W(CTL_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctrl(ctrl), .byte_cnt(byte_cnt),
  .word_cnt(word_cnt), .status(status), .rx_ready(rx_ready), .rx_take(rx_take),
  .tx_valid(tx_valid), .tx_send(tx_send), .win_re(win_re), .win_rdata(win_rdata),
  .fifo_cnt(fifo_cnt)
);

// File: tb/card_fifo_engine_tb_top.sv
module card_fifo_engine_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic        len_we, ctl_we, win_we, win_re, rx_valid, tx_ready;
  logic [15:0] len_wdata;
  logic [7:0]  ctl_wdata, rx_byte;
  logic [31:0] win_wdata;
  logic [31:0] win_rdata;
  logic        rx_ready, tx_valid;
  logic [7:0]  tx_byte, ctrl;
  logic [15:0] byte_cnt, word_cnt;
  logic [21:0] status;

  card_fifo_engine dut_i (
    .clk(clk), .rst_n(rst_n), .len_we(len_we), .len_wdata(len_wdata),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .win_we(win_we), .win_wdata(win_wdata),
    .win_re(win_re), .win_rdata(win_rdata), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_ready(tx_ready),
    .ctrl(ctrl), .byte_cnt(byte_cnt), .word_cnt(word_cnt), .status(status)
  );

  int checks = 0;
  int errors = 0;
  string cur_tag = "R1";

  // behavioural reference state
  logic [31:0] q[$];
  int tbq[$];
  int bc, wc, ctl_m, len_m, dend, racc, rn;
  bit e_rx, e_tx;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s/%s %s: actual %0h expected %0h", req, cur_tag, what, act, exp);
    end
  endtask

  task automatic compare();
    int cnt = q.size();
    bit en = ctl_m[0];
    bit dr = ctl_m[1];
    bit act_on = en && (bc != 0 || wc != 0);
    logic [31:0] e_rd, flags;
    e_rx = en && dr && bc != 0 && cnt < 16 && !ctl_we;
    e_tx = en && !dr && bc != 0 && (tbq.size() > 0 || cnt > 0) && !ctl_we;
    e_rd = (win_re && !ctl_we && wc != 0 && dr && cnt > 0) ? q[0] : 32'd0;
    flags = 0;
    if (act_on) begin
      if (dr) begin
        flags[13] = 1; flags[15] = (cnt >= 8); flags[17] = (cnt == 16);
        flags[19] = (cnt == 0); flags[21] = (cnt != 0);
      end else begin
        flags[12] = 1; flags[14] = (cnt <= 8); flags[16] = (cnt == 16);
        flags[18] = (cnt == 0); flags[20] = (cnt != 0);
      end
    end
    chk("R5", "rx_ready", 32'(rx_ready), 32'(e_rx));
    chk("R6", "tx_valid", 32'(tx_valid), 32'(e_tx));
    if (e_tx) chk("R6", "tx_byte", 32'(tx_byte), (tbq.size() > 0) ? 32'(tbq[0]) : (q[0] & 32'hFF));
    chk("R7", "win_rdata", win_rdata, e_rd);
    chk("R2", "byte_cnt", 32'(byte_cnt), 32'(bc));
    chk("R7", "word_cnt", 32'(word_cnt), 32'(wc));
    chk("R9", "ctrl", 32'(ctrl), 32'(ctl_m));
    chk("R8", "end bits", 32'({status[10], status[8]}), dend ? 32'd3 : 32'd0);
    chk("R10", "fifo flags", 32'(status) & 32'h3FF000, flags);
  endtask

  task automatic model_step();
    int pre = q.size();
    bit en = ctl_m[0];
    bit dr = ctl_m[1];
    bit hacc;
    logic [31:0] w;
    if (ctl_we) begin
      ctl_m = ctl_wdata;
      racc = 0; rn = 0; tbq.delete();
      if (ctl_wdata[0]) begin
        bc = len_m; wc = (len_m + 3) / 4; dend = 0; q.delete();
      end
    end else begin
      bit drop = en && bc == 0 && wc == 0;
      if (en && bc == 0) dend = 1;
      hacc = (win_we || win_re) && wc != 0;
      if (dr) begin
        if (hacc && win_re && pre > 0) void'(q.pop_front());
        if (e_rx && rx_valid) begin
          racc = racc | (int'(rx_byte) << (8 * rn));
          rn++;
          if (rn == 4 || bc == 1) begin
            if (pre < 16) q.push_back(racc);
            racc = 0; rn = 0;
          end
          bc--;
        end
      end else begin
        if (e_tx && tx_ready) begin
          if (tbq.size() == 0) begin
            w = q.pop_front();
            tbq.push_back(int'(w[15:8])); tbq.push_back(int'(w[23:16])); tbq.push_back(int'(w[31:24]));
          end else void'(tbq.pop_front());
          bc--;
        end
        if (hacc && win_we && pre < 16) q.push_back(win_wdata);
      end
      if (hacc) wc--;
      if (drop) ctl_m = ctl_m & ~1;
    end
    if (len_we) len_m = len_wdata;
  endtask

  task automatic cyc();
    #1;
    compare();
    model_step();
    @(negedge clk);
    len_we = 0; ctl_we = 0; win_we = 0; win_re = 0;
  endtask

  task automatic set_len(int v); len_we = 1; len_wdata = 16'(v); cyc(); endtask
  task automatic set_ctl(int v); ctl_we = 1; ctl_wdata = 8'(v); cyc(); endtask
  task automatic hwr(logic [31:0] d); win_we = 1; win_wdata = d; cyc(); endtask
  task automatic hrd(); win_re = 1; cyc(); endtask
  task automatic idle(int n); for (int i = 0; i < n; i++) cyc(); endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    rst_n = 0; len_we = 0; ctl_we = 0; win_we = 0; win_re = 0; rx_valid = 0; tx_ready = 0;
    len_wdata = 0; ctl_wdata = 0; rx_byte = 0; win_wdata = 0;
    bc = 0; wc = 0; ctl_m = 0; len_m = 0; dend = 0; racc = 0; rn = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    cur_tag = "R1"; cyc();

    // R4 ten-byte read: two full words and a two-byte tail
    cur_tag = "R4";
    set_len(10); set_ctl(8'h03);
    rx_valid = 1;
    for (int k = 0; k < 12; k++) begin rx_byte = 8'(8'h10 + k); cyc(); end
    rx_valid = 0;
    for (int k = 0; k < 4; k++) hrd();
    idle(2);

    // R5 fill to 16 words, engine stalls on full
    cur_tag = "R5";
    set_len(80); set_ctl(8'h03);
    rx_valid = 1;
    for (int k = 0; k < 70; k++) begin rx_byte = 8'(k); cyc(); end
    // R3 host pop coinciding with packer push
    cur_tag = "R3";
    for (int k = 0; k < 20; k++) begin win_re = 1; rx_byte = 8'(k + 100); cyc(); end
    rx_valid = 0;
    for (int k = 0; k < 10; k++) hrd();

    // R6 seven-byte write, lowest byte first
    cur_tag = "R6";
    tx_ready = 0;
    set_len(7); set_ctl(8'h01);
    hwr(32'h44332211); hwr(32'h88776655); hwr(32'hDEADBEEF);
    tx_ready = 1; idle(10); tx_ready = 0;

    // R3 full FIFO push dropped, then push and pop together
    cur_tag = "R3";
    set_len(80); set_ctl(8'h01);
    for (int k = 0; k < 17; k++) hwr(32'h01010101 * (k + 1));
    tx_ready = 1;
    for (int k = 0; k < 6; k++) hwr(32'hA0B0C000 + k);
    idle(90); tx_ready = 0;

    // R11 no movement while disabled
    cur_tag = "R11";
    set_ctl(8'h02);
    rx_valid = 1; rx_byte = 8'h5A; idle(4); rx_valid = 0;
    set_ctl(8'h00);
    tx_ready = 1; idle(3); tx_ready = 0;

    // R8 zero-length transfer
    cur_tag = "R8";
    set_len(0); set_ctl(8'h01); idle(3);

    // R9 enable held until host words drained
    cur_tag = "R9";
    set_len(5); set_ctl(8'h03);
    rx_valid = 1;
    for (int k = 0; k < 6; k++) begin rx_byte = 8'(8'hC0 + k); cyc(); end
    rx_valid = 0; idle(2);
    hrd(); idle(1); hrd(); idle(3);

    // R10 mixed traffic in both directions
    cur_tag = "R10";
    lf = 16'hACE1;
    for (int d = 0; d < 2; d++) begin
      set_len(40 + d * 3); set_ctl(d == 0 ? 8'h03 : 8'h01);
      for (int k = 0; k < 300; k++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        rx_valid  = lf[0];
        tx_ready  = lf[1];
        win_re    = lf[2] & lf[3];
        win_we    = lf[4] & lf[5];
        rx_byte   = lf[15:8];
        win_wdata = {lf, ~lf};
        cyc();
      end
      rx_valid = 0; tx_ready = 0;
    end
    idle(2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule